// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single register-side accesses into timed cycles on an 8-bit asynchronous NAND flash bus. An access names one of four kinds: a command byte, an address byte, a data byte to write, or a data byte to read. Each access is driven as three phases. In the setup phase the bus is driven and the strobe is inactive. In the width phase the write or read strobe is active. In the hold phase the strobe is released and the bus is still driven. The length of each phase comes from a packed timing word, with separate fields for reads and for writes.

Command accesses raise the command latch line and address accesses raise the address latch line for the whole access. Chip enable is active during every access. A configuration bit can also hold chip enable active while the bus is idle. After each access the ready/busy pin is observed only once a programmable delay has elapsed, so the device has time to pull it low. Requests use a valid/ready handshake, so a request made while an access is running waits and is not lost. A synchronous soft reset aborts any access and clears the configuration.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset the bus is idle: `req_ready`=1, `nand_we_n`=`nand_re_n`=1, `nand_cle`=`nand_ale`=0, `nand_ce_n`=1 and `nand_dq_oe`=0. With `nand_rb`=1, `dev_ready` reads 1 a few cycles later.
- R2: The timing word holds eight 4-bit fields. Bits 3:0 are read setup, 7:4 read hold, 11:8 read width and 15:12 read ready-delay. Bits 19:16 are write setup, 23:20 write hold, 27:24 write width and 31:28 write ready-delay. A write-type access (kind 0 command, 1 address, 2 write data) has a setup of n+1 cycles, then `nand_we_n` low for width+1 cycles, then a hold of n+1 cycles, with n taken from the write fields.
- R3: A read access (kind 3) uses the read fields and pulses `nand_re_n` low instead. `nand_dq_in` is captured into `rd_data` at the edge where the strobe is released. `rd_valid` is high for the single following cycle.
- R4: Kind 0 holds `nand_cle` high for every cycle of the access. Kind 1 holds `nand_ale` high for every cycle of the access. The other kinds raise neither line.
- R5: `nand_ce_n` is low in every cycle of an access. Between accesses it is high when the force bit (`cfg_ce_force`, written with `cfg_we`) is clear, and low when that bit is set.
- R6: In the cycle an access ends, `dev_ready` drops to 0. It stays 0 for 2*d+1 cycles, where d is the ready-delay field for the access direction. After that it follows the synchronised `nand_rb`.
- R7: `req_ready` is low from the cycle after an access is accepted until its hold phase ends. A request held during that time is accepted exactly once, when the sequencer becomes idle.
- R8: `soft_rst` aborts any access within one cycle and clears the timing word and the force bit to 0.
- R9: The timing fields are captured when an access is accepted. A timing write made during an access only affects later accesses.
- R10: `nand_dq_oe` is high throughout write-type accesses and `nand_dq_out` carries the request byte. `nand_dq_oe` stays low throughout read accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous abort and configuration clear |
| tim_we | input | 1 | Timing word write strobe |
| tim_wdata | input | 32 | Timing word value |
| cfg_we | input | 1 | Force-bit write strobe |
| cfg_ce_force | input | 1 | Value for the chip-enable force bit |
| req_valid | input | 1 | Access request valid |
| req_kind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_wdata | input | 8 | Byte for write-type accesses |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` updated |
| rd_data | output | 8 | Last byte read |
| dev_ready | output | 1 | Sampled device ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus value driven out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus value from the device |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
Two functions can fall in the same cycle: the end of one access's hold phase and the acceptance decision for a request that has been waiting. At the same moment the ready-delay window for the finished access starts. The bench keeps a second request valid from the first setup cycle onward. It then checks that the request is taken exactly once, one cycle after `req_ready` returns, and that its own byte appears during its strobe. A second overlap is a timing-word write made during an access. It is judged by measuring the phase lengths of that access and of the next one.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
   typedef enum logic [1:0] {
      K_CMD   = 2'd0,
      K_ADDR  = 2'd1,
      K_WDATA = 2'd2,
      K_RDATA = 2'd3
   } nsq_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_PULSE = 2'd2,
      PH_HOLD  = 2'd3
   } nsq_phase_e;

   localparam int unsigned NUM_FIELDS = 8;
   localparam int unsigned F_RSETUP = 0;
   localparam int unsigned F_RHOLD  = 1;
   localparam int unsigned F_RWIDTH = 2;
   localparam int unsigned F_RRDY   = 3;
   localparam int unsigned F_WSETUP = 4;
   localparam int unsigned F_WHOLD  = 5;
   localparam int unsigned F_WWIDTH = 6;
   localparam int unsigned F_WRDY   = 7;
endpackage

// File: rtl/nsq_cfg_regs.sv
module nsq_cfg_regs #(
   parameter int unsigned FIELD_W = 4,
   localparam int unsigned TW = nsq_pkg::NUM_FIELDS * FIELD_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          tim_we,
   input  logic [TW-1:0] tim_wdata,
   input  logic          cfg_we,
   input  logic          cfg_ce_force,
   output logic [TW-1:0] timing,
   output logic          ce_force
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing   <= '0;
         ce_force <= 1'b0;
      end else if (soft_rst) begin
         timing   <= '0;
         ce_force <= 1'b0;
      end else begin
         if (tim_we) timing   <= tim_wdata;
         if (cfg_we) ce_force <= cfg_ce_force;
      end
   end
endmodule

// File: rtl/nsq_phase_fsm.sv
module nsq_phase_fsm
   import nsq_pkg::*;
#(
   parameter int unsigned FIELD_W = 4,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned TW = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic [TW-1:0]      timing,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [DATA_W-1:0]  dq_in,
   output logic               req_ready,
   output nsq_phase_e         phase,
   output nsq_kind_e          kind_q,
   output logic [DATA_W-1:0]  wdata_q,
   output logic               access_done,
   output logic [FIELD_W-1:0] rdy_delay_q,
   output logic [DATA_W-1:0]  rd_data,
   output logic               rd_valid
);
   logic [FIELD_W-1:0] cnt, width_q, hold_q;
   logic               is_rd;

   function automatic logic [FIELD_W-1:0] fld(input logic [TW-1:0] w, input int unsigned idx);
      return w[idx*FIELD_W +: FIELD_W];
   endfunction

   assign is_rd       = (nsq_kind_e'(req_kind) == K_RDATA);
   assign req_ready   = (phase == PH_IDLE);
   assign access_done = (phase == PH_HOLD) && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;  kind_q <= K_CMD;  wdata_q <= '0;
         cnt <= '0;  width_q <= '0;  hold_q <= '0;  rdy_delay_q <= '0;
         rd_data <= '0;  rd_valid <= 1'b0;
      end else if (soft_rst) begin
         phase <= PH_IDLE;  cnt <= '0;  rd_valid <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         unique case (phase)
            PH_IDLE: if (req_valid) begin
               kind_q      <= nsq_kind_e'(req_kind);
               wdata_q     <= req_wdata;
               cnt         <= fld(timing, is_rd ? F_RSETUP : F_WSETUP);
               width_q     <= fld(timing, is_rd ? F_RWIDTH : F_WWIDTH);
               hold_q      <= fld(timing, is_rd ? F_RHOLD  : F_WHOLD);
               rdy_delay_q <= fld(timing, is_rd ? F_RRDY   : F_WRDY);
               phase       <= PH_SETUP;
            end
            PH_SETUP: if (cnt == '0) begin
               phase <= PH_PULSE;
               cnt   <= width_q;
            end else cnt <= cnt - 1'b1;
            PH_PULSE: if (cnt == '0) begin
               phase <= PH_HOLD;
               cnt   <= hold_q;
               if (kind_q == K_RDATA) begin
                  rd_data  <= dq_in;
                  rd_valid <= 1'b1;
               end
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt == '0) phase <= PH_IDLE;
                     else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nsq_ready_sampler.sv
module nsq_ready_sampler #(
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               rb_in,
   input  logic               start,
   input  logic [FIELD_W-1:0] delay,
   output logic               dev_ready
);
   logic               rb_s;
   logic               pend;
   logic [FIELD_W:0]   cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rb_s = rb_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= (sh << 1) | SYNC_STAGES'(rb_in);
         end
         assign rb_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;  cnt <= '0;  dev_ready <= 1'b0;
      end else if (soft_rst) begin
         pend <= 1'b0;  cnt <= '0;  dev_ready <= 1'b0;
      end else if (start) begin
         pend      <= 1'b1;
         cnt       <= {delay, 1'b0};
         dev_ready <= 1'b0;
      end else if (pend) begin
         if (cnt == '0) begin
            pend      <= 1'b0;
            dev_ready <= rb_s;
         end else cnt <= cnt - 1'b1;
      end else begin
         dev_ready <= rb_s;
      end
   end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nsq_pkg::*;
#(
   parameter int unsigned FIELD_W     = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned TW = NUM_FIELDS * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              tim_we,
   input  logic [TW-1:0]     tim_wdata,
   input  logic              cfg_we,
   input  logic              cfg_ce_force,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              dev_ready,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [DATA_W-1:0] nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [DATA_W-1:0] nand_dq_in,
   input  logic              nand_rb
);
   generate
      if (FIELD_W < 1 || FIELD_W > 8) begin : g_bad_field
         $error("FIELD_W must be 1..8");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic [TW-1:0]      timing;
   logic               ce_force;
   nsq_phase_e         phase;
   nsq_kind_e          kind_q;
   logic               access_done;
   logic [FIELD_W-1:0] rdy_delay_q;
   logic               busy, strobe_on, rd_acc;

   nsq_cfg_regs #(.FIELD_W(FIELD_W)) u_cfg (
      .clk, .rst_n, .soft_rst, .tim_we, .tim_wdata, .cfg_we, .cfg_ce_force,
      .timing, .ce_force
   );

   nsq_phase_fsm #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_fsm (
      .clk, .rst_n, .soft_rst, .timing, .req_valid, .req_kind, .req_wdata,
      .dq_in(nand_dq_in), .req_ready, .phase, .kind_q, .wdata_q(nand_dq_out),
      .access_done, .rdy_delay_q, .rd_data, .rd_valid
   );

   nsq_ready_sampler #(.FIELD_W(FIELD_W), .SYNC_STAGES(SYNC_STAGES)) u_rdy (
      .clk, .rst_n, .soft_rst, .rb_in(nand_rb), .start(access_done),
      .delay(rdy_delay_q), .dev_ready
   );

   assign busy       = (phase != PH_IDLE);
   assign strobe_on  = (phase == PH_PULSE);
   assign rd_acc     = (kind_q == K_RDATA);
   assign nand_cle   = busy && (kind_q == K_CMD);
   assign nand_ale   = busy && (kind_q == K_ADDR);
   assign nand_we_n  = !(strobe_on && !rd_acc);
   assign nand_re_n  = !(strobe_on && rd_acc);
   assign nand_ce_n  = !(busy || ce_force);
   assign nand_dq_oe = busy && !rd_acc;
endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_rst,
   input logic req_valid,
   input logic req_ready,
   input logic rd_valid,
   input logic dev_ready,
   input logic nand_ce_n,
   input logic nand_cle,
   input logic nand_ale,
   input logic nand_we_n,
   input logic nand_re_n,
   input logic nand_dq_oe
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe)); // R1
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n)); // R3
   AST_RDV_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (!req_ready && nand_re_n)); // R3
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale)); // R4
   AST_CE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R5
   AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> !dev_ready); // R6
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !soft_rst) |=> !req_ready); // R7
   AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (req_ready && nand_we_n && nand_re_n)); // R8
   AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      nand_dq_oe |-> nand_re_n); // R10
endmodule

bind nand_strobe_seq nand_strobe_seq_chk u_chk (
   .clk, .rst_n, .soft_rst, .req_valid, .req_ready, .rd_valid, .dev_ready,
   .nand_ce_n, .nand_cle, .nand_ale, .nand_we_n, .nand_re_n, .nand_dq_oe
);

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, tim_we = 1'b0, cfg_we = 1'b0, cfg_ce_force = 1'b0;
   logic [31:0] tim_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [7:0]  req_wdata = '0, nand_dq_in = 8'h00;
   logic        nand_rb = 1'b1;
   logic        req_ready, rd_valid, dev_ready, nand_ce_n, nand_cle, nand_ale;
   logic        nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  rd_data, nand_dq_out;

   int checks = 0, errors = 0;
   int m_setup, m_pulse, m_hold, m_cle, m_ale, m_busy, m_oe, m_cebad, m_rdv, m_rdylow;
   logic [7:0] m_pulse_dq, m_rdv_data;

   localparam logic [31:0] T1 = 32'h2312_1421;
   localparam logic [31:0] T2 = 32'h0F0F_0F0F;

   always #2 clk = ~clk;

   nand_strobe_seq u_nand_strobe_seq (.*);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_timing(input logic [31:0] w);
      @(negedge clk); tim_we = 1'b1; tim_wdata = w;
      @(negedge clk); tim_we = 1'b0;
   endtask

   task automatic set_force(input logic v);
      @(negedge clk); cfg_we = 1'b1; cfg_ce_force = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // Observe an access from its first setup cycle until idle, then the ready window.
   task automatic observe(input bit rd, input bit mid_write, input logic [31:0] mid_word);
      m_setup = 0; m_pulse = 0; m_hold = 0; m_cle = 0; m_ale = 0; m_busy = 0;
      m_oe = 0; m_cebad = 0; m_rdv = 0; m_rdylow = 0; m_pulse_dq = 'x; m_rdv_data = 'x;
      for (int i = 0; i < 100 && !req_ready; i++) begin
         if (mid_write && i == 0) begin tim_we = 1'b1; tim_wdata = mid_word; end
         else tim_we = 1'b0;
         m_busy++;
         if (nand_cle) m_cle++;
         if (nand_ale) m_ale++;
         if (nand_dq_oe) m_oe++;
         if (nand_ce_n) m_cebad++;
         if (rd_valid) begin m_rdv++; m_rdv_data = rd_data; end
         if (rd ? !nand_re_n : !nand_we_n) begin m_pulse++; m_pulse_dq = nand_dq_out; end
         else if (m_pulse == 0) m_setup++;
         else m_hold++;
         @(negedge clk);
      end
      tim_we = 1'b0;
      for (int i = 0; i < 100 && !dev_ready; i++) begin
         m_rdylow++;
         @(negedge clk);
      end
   endtask

   task automatic issue(input logic [1:0] kind, input logic [7:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ready", int'(req_ready), 1);
      check("R1 we_n", int'(nand_we_n), 1);
      check("R1 re_n", int'(nand_re_n), 1);
      check("R1 cle/ale", int'(nand_cle | nand_ale), 0);
      check("R1 ce_n", int'(nand_ce_n), 1);
      check("R1 oe", int'(nand_dq_oe), 0);
      repeat (5) @(negedge clk);
      check("R1 dev_ready", int'(dev_ready), 1);
   endtask

   task automatic t_write_data();
      set_timing(T1);
      issue(2'd2, 8'hA5);
      observe(1'b0, 1'b0, '0);
      check("R2 setup", m_setup, 3);
      check("R2 width", m_pulse, 4);
      check("R2 hold", m_hold, 2);
      check("R10 oe cycles", m_oe, 9);
      check("R10 dq byte", int'(m_pulse_dq), 8'hA5);
      check("R6 write delay", m_rdylow, 5);
      check("R4 data no latch", m_cle + m_ale, 0);
   endtask

   task automatic t_read();
      nand_dq_in = 8'h3C;
      issue(2'd3, 8'h00);
      observe(1'b1, 1'b0, '0);
      check("R3 setup", m_setup, 2);
      check("R3 width", m_pulse, 5);
      check("R3 hold", m_hold, 3);
      check("R3 rd_valid count", m_rdv, 1);
      check("R3 rd_data", int'(m_rdv_data), 8'h3C);
      check("R10 read oe", m_oe, 0);
      check("R6 read delay", m_rdylow, 3);
   endtask

   task automatic t_cmd_addr();
      issue(2'd0, 8'h70);
      observe(1'b0, 1'b0, '0);
      check("R4 cle cycles", m_cle, m_busy);
      check("R4 cmd ale", m_ale, 0);
      check("R4 cmd byte", int'(m_pulse_dq), 8'h70);
      issue(2'd1, 8'h12);
      observe(1'b0, 1'b0, '0);
      check("R4 ale cycles", m_ale, m_busy);
      check("R4 addr cle", m_cle, 0);
   endtask

   task automatic t_ce();
      check("R5 idle ce_n", int'(nand_ce_n), 1);
      check("R5 access ce", m_cebad, 0);
      set_force(1'b1);
      check("R5 forced ce_n", int'(nand_ce_n), 0);
      set_force(1'b0);
      check("R5 released ce_n", int'(nand_ce_n), 1);
   endtask

   task automatic t_stall();
      int accepts = 0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd2; req_wdata = 8'h11;
      @(negedge clk);
      req_wdata = 8'h22;   // second request waits behind the first
      for (int i = 0; i < 60; i++) begin
         if (req_ready && req_valid) begin accepts++; break; end
         @(negedge clk);
      end
      @(negedge clk);
      req_valid = 1'b0;
      check("R7 accept on idle", accepts, 1);
      check("R7 busy after accept", int'(req_ready), 0);
      observe(1'b0, 1'b0, '0);
      check("R7 second byte", int'(m_pulse_dq), 8'h22);
      check("R7 second timing", m_setup + m_pulse + m_hold, 9);
      check("R7 no extra access", int'(req_ready), 1);
   endtask

   task automatic t_latch();
      issue(2'd2, 8'h5A);
      observe(1'b0, 1'b1, T2);
      check("R9 old setup", m_setup, 3);
      check("R9 old width", m_pulse, 4);
      check("R9 old hold", m_hold, 2);
      issue(2'd2, 8'h5B);
      observe(1'b0, 1'b0, '0);
      check("R9 new setup max", m_setup, 16);
      check("R9 new width max", m_pulse, 16);
      check("R9 new hold min", m_hold, 1);
      check("R6 zero delay", m_rdylow, 1);
   endtask

   task automatic t_soft();
      set_timing(T1);
      set_force(1'b1);
      issue(2'd2, 8'h99);
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      check("R8 idle", int'(req_ready), 1);
      check("R8 we_n", int'(nand_we_n), 1);
      check("R8 force cleared", int'(nand_ce_n), 1);
      nand_dq_in = 8'hC3;
      issue(2'd3, 8'h00);
      observe(1'b1, 1'b0, '0);
      check("R8 timing cleared", m_setup * 100 + m_pulse * 10 + m_hold, 111);
      check("R8 read data", int'(m_rdv_data), 8'hC3);
   endtask

   task automatic t_busy_pin();
      set_timing(T1);
      nand_rb = 1'b0;
      issue(2'd0, 8'hFF);
      observe(1'b0, 1'b0, '0);
      repeat (3) @(negedge clk);
      check("R6 busy pin seen", int'(dev_ready), 0);
      nand_rb = 1'b1;
      repeat (4) @(negedge clk);
      check("R6 ready follows pin", int'(dev_ready), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_data();
      t_read();
      t_cmd_addr();
      t_ce();
      t_stall();
      t_latch();
      t_soft();
      t_busy_pin();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule